// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block is the per-port dispatch stage of a storage host adapter. Software posts commands by setting bits in a slot-issue register, one bit per command slot. The block chooses the lowest pending slot and offers its index to a command engine over a valid/ready handshake. It then waits for the engine's completion report and retires the slot, either at once or later, when the engine goes idle.

The block also holds the port command/status register and a serial-control detect field. The command/status register has a start bit, a receive-enable bit and two running indications that hardware derives from them. A one-shot pulse asks for the initial status report the first time receive-running is set. A 1-to-0 move of the detect field resets the port and re-arms that one-shot.

Back-pressure rules for the dispatch stream: once `disp_valid` is high, it stays high and `disp_slot` stays constant until a cycle with `disp_ready` high. Only a port reset withdraws an offer. Clearing the start bit after an offer does not withdraw it. At most one slot is in flight. No new offer appears between a handshake and the matching `cmp_valid`.

Top module: `slot_issue_sched`

## Requirements
- R1: A write to address 0 ORs the write data into the pending-slot vector. Software cannot clear a bit by writing. A read of address 0 returns the live pending bits.
- R2: Among pending slots, the lowest-numbered slot is offered first.
- R3: A slot is offered only while the start bit (bit 0 of the command register at address 1) is set.
- R4: No slot is offered while `eng_busy` or `eng_drq` is high.
- R5: While `disp_valid` is high without `disp_ready`, the offer and `disp_slot` stay unchanged. After a handshake, no new offer appears until `cmp_valid` arrives.
- R6: `cmp_valid` with `cmp_defer` low clears the issue bit of the in-flight slot on that clock edge.
- R7: `cmp_valid` with `cmp_defer` high records the slot as the busy slot. While a busy slot is recorded, no slot is offered. Its issue bit clears on the first edge at which `eng_busy` and `eng_drq` are both low, and scanning then resumes.
- R8: A write to the command register stores start (bit 0) and receive-enable (bit 1). The written values of bit 2 (receive-running) and bit 3 (list-running) are ignored. Those bits are loaded from bit 1 and bit 0 of the written value. Bits above 3 read as zero.
- R9: `init_pulse` is high for exactly one cycle after the first command-register write that sets receive-enable since reset or port reset. It does not pulse again until the next port reset.
- R10: A write to address 2 that moves the detect field (bits 3:0) from 1 to 0 resets the port. The reset clears the busy slot and re-arms the one-shot. Any other detect transition does not.
- R11: After reset, all registers read zero, and `disp_valid` and `init_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 issue, 1 command, 2 serial control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_busy | input | 1 | Engine busy flag |
| eng_drq | input | 1 | Engine data-request flag |
| disp_valid | output | 1 | Slot offer valid |
| disp_slot | output | 5 | Offered slot index |
| disp_ready | input | 1 | Engine accepts the offer |
| cmp_valid | input | 1 | Completion report for the in-flight slot |
| cmp_defer | input | 1 | Completion leaves the engine busy (deferred retire) |
| init_pulse | output | 1 | One-shot initial status-report request |

## Verification
The assertions check these properties on every cycle:
- Pending bits are only ever cleared by a retire.
- A new offer always carries the lowest slot pending in the cycle before.
- Offers begin only when start is set and the engine is idle, and an unaccepted offer holds steady.
- A recorded busy slot blocks any new offer.
- The one-shot never lasts two cycles and never fires unarmed.

Only the bench scenarios can show the behaviours that need a timed sequence of stimulus:
- The deferred slot stays set while only one of busy and data-request has dropped.
- A port reset forgets the busy slot, so the slot is offered again rather than retired.
- A detect move from 2 to 0 leaves the one-shot spent.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_ISSUE = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMD   = 2'd1;
  localparam logic [ADDR_W-1:0] A_SCTL  = 2'd2;
  localparam int B_START  = 0;
  localparam int B_RXEN   = 1;
  localparam int B_RXRUN  = 2;
  localparam int B_LSTRUN = 3;
  localparam int DET_W    = 4;
  typedef enum logic [1:0] {S_IDLE, S_OFFER, S_WAIT} disp_st_e;
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [SW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = SW'(i);
    end
  end
endmodule

// File: rtl/sched_port_ctl.sv
module sched_port_ctl
  import slot_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DET_W-1:0]  wdata,
  output logic              start,
  output logic              rx_en,
  output logic              list_run,
  output logic              rx_run,
  output logic [DET_W-1:0]  detect,
  output logic              init_pulse,
  output logic              port_rst
);
  logic armed_q;
  logic cmd_wr;

  assign cmd_wr   = we && (addr == A_CMD);
  assign port_rst = we && (addr == A_SCTL) && (detect == DET_W'(1)) && (wdata == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start      <= 1'b0;
      rx_en      <= 1'b0;
      list_run   <= 1'b0;
      rx_run     <= 1'b0;
      detect     <= '0;
      init_pulse <= 1'b0;
      armed_q    <= 1'b1;
    end else begin
      init_pulse <= 1'b0;
      if (cmd_wr) begin
        start    <= wdata[B_START];
        rx_en    <= wdata[B_RXEN];
        list_run <= wdata[B_START];
        rx_run   <= wdata[B_RXEN];
        if (wdata[B_RXEN] && armed_q) begin
          init_pulse <= 1'b1;
          armed_q    <= 1'b0;
        end
      end
      if (we && (addr == A_SCTL)) detect <= wdata;
      if (port_rst) armed_q <= 1'b1;
    end
  end

  // R9: the request lasts one cycle only
  p_oneshot_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !init_pulse);
  // R9: a pulse needs the arm flag in the cycle before
  p_oneshot_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_pulse) |-> $past(armed_q));
  // R8: running bits track the written control bits
  p_run_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (list_run == start) && (rx_run == rx_en));
endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
  import slot_sched_pkg::*;
#(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_rst,
  input  logic          go,
  input  logic          eng_idle,
  input  logic          pick_any,
  input  logic [SW-1:0] pick_idx,
  input  logic          disp_ready,
  input  logic          cmp_valid,
  input  logic          cmp_defer,
  output logic          disp_valid,
  output logic [SW-1:0] disp_slot,
  output logic [N-1:0]  clr_mask
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  disp_st_e      st_q;
  logic [SW-1:0] slot_q;
  logic          occ_q;
  logic [SW-1:0] bidx_q;

  assign disp_valid = (st_q == S_OFFER);
  assign disp_slot  = slot_q;

  always_comb begin
    clr_mask = '0;
    if ((st_q == S_WAIT) && cmp_valid && !cmp_defer) clr_mask = clr_mask | (ONE << slot_q);
    if (occ_q && eng_idle) clr_mask = clr_mask | (ONE << bidx_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      slot_q <= '0;
      occ_q  <= 1'b0;
      bidx_q <= '0;
    end else if (port_rst) begin
      st_q  <= S_IDLE;
      occ_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go && pick_any && !occ_q) begin
          st_q   <= S_OFFER;
          slot_q <= pick_idx;
        end
        S_OFFER: if (disp_ready) st_q <= S_WAIT;
        S_WAIT: if (cmp_valid) begin
          st_q <= S_IDLE;
          if (cmp_defer) begin
            occ_q  <= 1'b1;
            bidx_q <= slot_q;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (occ_q && eng_idle) occ_q <= 1'b0;
    end
  end

  // R5: an unaccepted offer holds its slot
  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready && !port_rst) |=> (disp_valid && $stable(disp_slot)));
  // R3 and R4: a fresh offer needs start set and the engine idle
  p_offer_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> $past(go));
  // R7: a recorded busy slot blocks new offers
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && !port_rst) |=> !$rose(disp_valid));
endmodule

// File: rtl/slot_issue_sched.sv
module slot_issue_sched
  import slot_sched_pkg::*;
#(
  parameter int NSLOTS = 32,
  parameter int DW     = 32,
  localparam int SW    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_drq,
  output logic              disp_valid,
  output logic [SW-1:0]     disp_slot,
  input  logic              disp_ready,
  input  logic              cmp_valid,
  input  logic              cmp_defer,
  output logic              init_pulse
);
  logic [NSLOTS-1:0] pending_q;
  logic [NSLOTS-1:0] clr_mask;
  logic [NSLOTS-1:0] set_mask;
  logic              issue_wr;
  logic              start, rx_en, list_run, rx_run, port_rst;
  logic [DET_W-1:0]  detect;
  logic              pick_any;
  logic [SW-1:0]     pick_idx;
  logic              eng_idle;

  assign issue_wr = reg_we && (reg_addr == A_ISSUE);
  assign set_mask = issue_wr ? reg_wdata[NSLOTS-1:0] : '0;
  assign eng_idle = !eng_busy && !eng_drq;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= (pending_q & ~clr_mask) | set_mask;
  end

  sched_port_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[DET_W-1:0]), .start(start), .rx_en(rx_en),
    .list_run(list_run), .rx_run(rx_run), .detect(detect),
    .init_pulse(init_pulse), .port_rst(port_rst)
  );

  slot_pick #(.N(NSLOTS), .SW(SW)) u_pick (
    .req(pending_q), .any(pick_any), .idx(pick_idx)
  );

  dispatch_fsm #(.N(NSLOTS), .SW(SW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .go(start && eng_idle),
    .eng_idle(eng_idle), .pick_any(pick_any), .pick_idx(pick_idx),
    .disp_ready(disp_ready), .cmp_valid(cmp_valid), .cmp_defer(cmp_defer),
    .disp_valid(disp_valid), .disp_slot(disp_slot), .clr_mask(clr_mask)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_ISSUE: reg_rdata[NSLOTS-1:0] = pending_q;
      A_CMD: begin
        reg_rdata[B_START]  = start;
        reg_rdata[B_RXEN]   = rx_en;
        reg_rdata[B_RXRUN]  = rx_run;
        reg_rdata[B_LSTRUN] = list_run;
      end
      A_SCTL: reg_rdata[DET_W-1:0] = detect;
      default: reg_rdata = '0;
    endcase
  end

  // R1: a pending bit only drops through a retire
  p_or_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pending_q) & ~pending_q & ~$past(clr_mask)) == '0));
  // R2: a fresh offer is the lowest slot pending one cycle earlier
  p_lowest_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |->
      ((($past(pending_q) >> disp_slot) & NSLOTS'(1)) == NSLOTS'(1)) &&
      (($past(pending_q) & ((NSLOTS'(1) << disp_slot) - NSLOTS'(1))) == '0));
endmodule

// File: tb/slot_issue_sched_tb_top.sv
module slot_issue_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_busy = 1'b0, eng_drq = 1'b0;
  logic        disp_valid;
  logic [4:0]  disp_slot;
  logic        disp_ready = 1'b0, cmp_valid = 1'b0, cmp_defer = 1'b0;
  logic        init_pulse;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  slot_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_drq(eng_drq), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .disp_ready(disp_ready), .cmp_valid(cmp_valid), .cmp_defer(cmp_defer),
    .init_pulse(init_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_offer(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (disp_valid) seen = 1'b1;
    end
  endtask

  task automatic no_offer(input string tag, input int cyc);
    logic any = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (disp_valid) any = 1'b1;
    end
    chk(tag, {31'b0, any}, 32'd0);
  endtask

  task automatic accept();
    @(negedge clk); disp_ready = 1'b1;
    @(negedge clk); disp_ready = 1'b0;
  endtask

  task automatic complete(input logic d);
    @(negedge clk); cmp_valid = 1'b1; cmp_defer = d;
    @(negedge clk); cmp_valid = 1'b0; cmp_defer = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R11 issue", v, 0);
    rd(2'd1, v); chk("R11 cmd", v, 0);
    rd(2'd2, v); chk("R11 sctl", v, 0);
    chk("R11 valid", {31'b0, disp_valid}, 0);
    chk("R11 init_pulse", {31'b0, init_pulse}, 0);
  endtask

  task automatic t_or_write();
    logic [31:0] v;
    wr(2'd0, 32'h11); wr(2'd0, 32'h100);
    rd(2'd0, v); chk("R1 or-accumulate", v, 32'h111);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R1 no clear by write", v, 32'h111);
  endtask

  task automatic t_start_gate();
    no_offer("R3 no offer with start clear", 6);
  endtask

  task automatic t_cmd_oneshot();
    logic [31:0] v;
    wr(2'd1, 32'h2);
    chk("R9 first pulse", {31'b0, init_pulse}, 1);
    @(negedge clk); chk("R9 pulse width", {31'b0, init_pulse}, 0);
    rd(2'd1, v); chk("R8 rx running follows enable", v, 32'h6);
    wr(2'd1, 32'hFFFF_FFFC);
    rd(2'd1, v); chk("R8 run bits not writable", v, 32'h0);
    chk("R8 no offer", {31'b0, disp_valid}, 0);
    wr(2'd1, 32'h2);
    chk("R9 no second pulse", {31'b0, init_pulse}, 0);
    wr(2'd2, 32'h2); wr(2'd2, 32'h0); wr(2'd1, 32'h2);
    chk("R10 2->0 does not re-arm", {31'b0, init_pulse}, 0);
    wr(2'd2, 32'h1); wr(2'd2, 32'h0); wr(2'd1, 32'h2);
    chk("R10 1->0 re-arms", {31'b0, init_pulse}, 1);
    rd(2'd2, v); chk("R10 detect readback", v, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    logic seen;
    wr(2'd1, 32'h1);
    rd(2'd1, v); chk("R8 list running follows start", v, 32'h9);
    wait_offer(seen); chk("R2 offer seen", {31'b0, seen}, 1);
    chk("R2 lowest slot", {27'b0, disp_slot}, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R5 valid held", {31'b0, disp_valid}, 1);
    chk("R5 slot held", {27'b0, disp_slot}, 0);
    accept();
    no_offer("R5 no offer while in flight", 3);
    complete(1'b0);
    rd(2'd0, v); chk("R6 immediate clear", v, 32'h110);
    wait_offer(seen); chk("R2 second slot", {27'b0, disp_slot}, 4);
    accept(); complete(1'b0);
    wait_offer(seen); chk("R2 third slot", {27'b0, disp_slot}, 8);
    accept(); complete(1'b0);
    rd(2'd0, v); chk("R6 all cleared", v, 0);
  endtask

  task automatic t_engine_gate();
    logic seen;
    eng_busy = 1'b1;
    wr(2'd0, 32'h8);
    no_offer("R4 busy blocks", 5);
    @(negedge clk); eng_busy = 1'b0; eng_drq = 1'b1;
    no_offer("R4 drq blocks", 5);
    @(negedge clk); eng_drq = 1'b0;
    wait_offer(seen); chk("R4 offer after idle", {26'b0, seen, disp_slot}, 32'h23);
    accept(); complete(1'b0);
  endtask

  task automatic t_defer();
    logic [31:0] v;
    logic seen;
    wr(2'd0, 32'h3);
    wait_offer(seen); chk("R7 first offer", {27'b0, disp_slot}, 0);
    accept();
    eng_busy = 1'b1;
    complete(1'b1);
    no_offer("R7 occupied blocks", 4);
    rd(2'd0, v); chk("R7 bit kept while busy", v, 32'h3);
    @(negedge clk); eng_busy = 1'b0; eng_drq = 1'b1;
    no_offer("R7 drq still blocks", 4);
    rd(2'd0, v); chk("R7 bit kept while drq", v, 32'h3);
    @(negedge clk); eng_drq = 1'b0;
    rd(2'd0, v); chk("R7 retired on idle", v, 32'h2);
    wait_offer(seen); chk("R7 scan resumes", {26'b0, seen, disp_slot}, 32'h21);
    accept(); complete(1'b0);
  endtask

  task automatic t_port_reset();
    logic [31:0] v;
    logic seen;
    wr(2'd0, 32'h4);
    wait_offer(seen); chk("R10 offer", {27'b0, disp_slot}, 2);
    accept();
    eng_busy = 1'b1;
    complete(1'b1);
    wr(2'd2, 32'h1); wr(2'd2, 32'h0);
    @(negedge clk); eng_busy = 1'b0;
    rd(2'd0, v); chk("R10 busy slot forgotten", v, 32'h4);
    wait_offer(seen); chk("R10 slot offered again", {26'b0, seen, disp_slot}, 32'h22);
    accept(); complete(1'b0);
    rd(2'd0, v); chk("R6 cleared after re-run", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_or_write();
    t_start_gate();
    t_cmd_oneshot();
    t_order();
    t_engine_gate();
    t_defer();
    t_port_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule